// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel datapath of a four-channel DMA controller. Every channel holds a 16-bit current address and a 16-bit current count, and a base copy of each. The sequencer sends a transfer strobe and names a channel. The engine then presents that channel's current address, moves the address one step up or down, and counts the byte off. The count holds the transfer length minus one. The last byte is the one on which a count of zero is decremented.

At terminal count the engine raises a one-cycle pulse and sets the channel's sticky flag. If the channel's auto-initialize bit is set, the engine copies the base values back into the current registers. If it is clear, the engine masks the channel, and the channel stays masked until it is loaded again. A memory-to-memory mode pairs channel 0 and channel 1. Strobes then alternate between a read cycle on channel 0's address and a write cycle on channel 1's address. The byte read is held in an 8-bit temporary register and driven out on the write cycle. Channel 1's count decides when the block transfer ends.

Register programming is reduced to a single load port for each channel, and bus strobing is left to the sequencer.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset all four mask flags read 1, all terminal-count flags read 0 and `addr_vld` is 0. A strobe to a masked channel produces no address (`addr_vld` stays 0) and changes no state.
- R2: A cycle with `load_we` high writes `load_addr` and `load_cnt` into both the base and current registers of channel `load_ch`, and clears that channel's mask and terminal-count flags. A strobe to the same channel in that same cycle is dropped.
- R3: A strobe that is served gives `addr_vld`=1 in the cycle after the strobe's clock edge, with `addr_out` equal to the channel's address before the step. The address then rises by 1 when `dir_down[ch]`=0 and falls by 1 when it is 1, wrapping modulo 2^16.
- R4: A loaded count N gives exactly N+1 served transfers. `tc_pulse`=1 and `tc_ch`=ch arrive together with the address of the transfer on which a count of 0 is decremented. N=0 gives one byte and N=16'hFFFF gives 65536 bytes.
- R5: At terminal count `tc_flags[ch]` is set. When `auto_init[ch]`=0, `mask_flags[ch]` is also set, so further strobes to that channel are ignored.
- R6: When `auto_init[ch]`=1, terminal count reloads the current address and count from the base copies and leaves the mask clear. The next strobe outputs the base address again.
- R7: With `m2m_en`=1, `xfer_ch` is ignored and served strobes alternate, starting with a read after `m2m_en` rises. A read has `wr_phase`=0, uses channel 0's address and captures `data_in`. A write has `wr_phase`=1, uses channel 1's address and drives `data_out` with the captured byte.
- R8: In memory-to-memory mode only write cycles decrement a count, and it is channel 1's count. Terminal count reports `tc_ch`=1, and channel 0's count and flags are left unchanged. Strobes are served only while channels 0 and 1 are both unmasked.
- R9: `addr_vld` is 1 only in the cycle that follows a served strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Load the base and current registers of one channel |
| load_ch | input | 2 | Channel to load |
| load_addr | input | 16 | Start address |
| load_cnt | input | 16 | Byte total minus one |
| dir_down | input | 4 | Per channel: 1 steps the address down, 0 steps it up |
| auto_init | input | 4 | Per channel: reload from the base copies at terminal count |
| m2m_en | input | 1 | Memory-to-memory mode using channels 0 and 1 |
| xfer_stb | input | 1 | Transfer strobe from the sequencer |
| xfer_ch | input | 2 | Channel of the strobe (ignored in memory-to-memory mode) |
| data_in | input | 8 | Byte read on a memory-to-memory read cycle |
| addr_out | output | 16 | Address of the last served transfer |
| addr_vld | output | 1 | `addr_out` is valid this cycle |
| wr_phase | output | 1 | The transfer is a memory-to-memory write cycle |
| data_out | output | 8 | Held byte for the memory-to-memory write cycle |
| tc_pulse | output | 1 | Terminal count on this transfer |
| tc_ch | output | 2 | Channel that reached terminal count |
| tc_flags | output | 4 | Sticky terminal-count flag per channel |
| mask_flags | output | 4 | Mask flag per channel |

## Verification
The bench checks that terminal count lands exactly on the (N+1)th transfer for counts of 0, 1, 2 and 16'hFFFF. A design that fired on reaching zero rather than on leaving it would end one byte early. A design with a narrowed counter would never finish the 65536-byte burst. Address wrap in both directions is exercised from 16'h0000 downwards and across the top of a full burst, where a missing modulo step or an inverted direction bit shows up as a wrong address. Auto-initialize must give the base address on the very next strobe and leave the mask clear, while a channel without it must ignore the next strobe. A load that coincides with a strobe must drop the strobe, or the fresh address would be consumed at once. In memory-to-memory mode the bench looks for a read/write order that begins with a read, the captured byte on the write, terminal count taken from channel 1, and channel 0's count left untouched. A design that decremented channel 0 would raise terminal count on channel 0 during the copy.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } m2m_phase_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic [CW-1:0] upd_cnt,
  input  logic          set_tc,
  input  logic          set_mask,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic [AW-1:0] base_addr,
  output logic [CW-1:0] base_cnt,
  output logic          tc_flag,
  output logic          mask_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
      tc_flag   <= 1'b0;
      mask_flag <= 1'b1;
    end else if (ld_en) begin
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_cnt;
      base_addr <= ld_addr;
      base_cnt  <= ld_cnt;
      tc_flag   <= 1'b0;
      mask_flag <= 1'b0;
    end else if (upd_en) begin
      cur_addr <= upd_addr;
      cur_cnt  <= upd_cnt;
      if (set_tc)   tc_flag   <= 1'b1;
      if (set_mask) mask_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_stepper.sv
module dma_stepper #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] base_cnt,
  input  logic          down,
  input  logic          reload,
  input  logic          dec_en,
  output logic [AW-1:0] nxt_addr,
  output logic [CW-1:0] nxt_cnt,
  output logic          tc
);
  logic [AW-1:0] stepped;

  always_comb begin
    stepped  = down ? (addr - AW'(1)) : (addr + AW'(1));
    tc       = dec_en && (cnt == '0);
    nxt_addr = stepped;
    nxt_cnt  = cnt;
    if (dec_en) begin
      if (tc && reload) begin
        nxt_addr = base_addr;
        nxt_cnt  = base_cnt;
      end else begin
        nxt_cnt = cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_m2m_ctl.sv
module dma_m2m_ctl
  import dma_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m2m_en,
  input  logic          step,
  input  logic [DW-1:0] data_in,
  output m2m_phase_e    phase,
  output logic [DW-1:0] tmp
);
  always_ff @(posedge clk) begin
    if (rst || !m2m_en) begin
      phase <= PH_READ;
    end else if (step) begin
      phase <= (phase == PH_READ) ? PH_WRITE : PH_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp <= '0;
    end else if (m2m_en && step && phase == PH_READ) begin
      tmp <= data_in;
    end
  end
endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 8,
  localparam int CHW = $clog2(CH_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_we,
  input  logic [CHW-1:0]  load_ch,
  input  logic [AW-1:0]   load_addr,
  input  logic [CW-1:0]   load_cnt,
  input  logic [CH_N-1:0] dir_down,
  input  logic [CH_N-1:0] auto_init,
  input  logic            m2m_en,
  input  logic            xfer_stb,
  input  logic [CHW-1:0]  xfer_ch,
  input  logic [DW-1:0]   data_in,
  output logic [AW-1:0]   addr_out,
  output logic            addr_vld,
  output logic            wr_phase,
  output logic [DW-1:0]   data_out,
  output logic            tc_pulse,
  output logic [CHW-1:0]  tc_ch,
  output logic [CH_N-1:0] tc_flags,
  output logic [CH_N-1:0] mask_flags
);
  localparam logic [CHW-1:0] SRC_CH = CHW'(0);
  localparam logic [CHW-1:0] DST_CH = CHW'(1);

  logic [AW-1:0] cur_addr  [CH_N];
  logic [CW-1:0] cur_cnt   [CH_N];
  logic [AW-1:0] base_addr [CH_N];
  logic [CW-1:0] base_cnt  [CH_N];

  m2m_phase_e    phase;
  logic [DW-1:0] tmp;
  logic [CHW-1:0] act_ch;
  logic          ld_hits_act, ld_hits_pair, served, dec_en;
  logic [AW-1:0] nxt_addr;
  logic [CW-1:0] nxt_cnt;
  logic          step_tc;

  always_comb begin
    if (m2m_en) act_ch = (phase == PH_WRITE) ? DST_CH : SRC_CH;
    else        act_ch = xfer_ch;
    ld_hits_act  = load_we && (load_ch == act_ch);
    ld_hits_pair = load_we && (load_ch == SRC_CH || load_ch == DST_CH);
    if (m2m_en)
      served = xfer_stb && !mask_flags[SRC_CH] && !mask_flags[DST_CH] && !ld_hits_pair;
    else
      served = xfer_stb && !mask_flags[act_ch] && !ld_hits_act;
    dec_en = !m2m_en || (phase == PH_WRITE);
  end

  dma_stepper #(.AW(AW), .CW(CW)) stepper_i (
    .addr      (cur_addr[act_ch]),
    .cnt       (cur_cnt[act_ch]),
    .base_addr (base_addr[act_ch]),
    .base_cnt  (base_cnt[act_ch]),
    .down      (dir_down[act_ch]),
    .reload    (auto_init[act_ch]),
    .dec_en    (dec_en),
    .nxt_addr  (nxt_addr),
    .nxt_cnt   (nxt_cnt),
    .tc        (step_tc)
  );

  dma_m2m_ctl #(.DW(DW)) m2m_i (
    .clk     (clk),
    .rst     (rst),
    .m2m_en  (m2m_en),
    .step    (served),
    .data_in (data_in),
    .phase   (phase),
    .tmp     (tmp)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    logic upd;
    assign upd = served && (act_ch == CHW'(g));
    dma_chan_regs #(.AW(AW), .CW(CW)) regs_i (
      .clk       (clk),
      .rst       (rst),
      .ld_en     (load_we && (load_ch == CHW'(g))),
      .ld_addr   (load_addr),
      .ld_cnt    (load_cnt),
      .upd_en    (upd),
      .upd_addr  (nxt_addr),
      .upd_cnt   (nxt_cnt),
      .set_tc    (upd && step_tc),
      .set_mask  (upd && step_tc && !auto_init[g]),
      .cur_addr  (cur_addr[g]),
      .cur_cnt   (cur_cnt[g]),
      .base_addr (base_addr[g]),
      .base_cnt  (base_cnt[g]),
      .tc_flag   (tc_flags[g]),
      .mask_flag (mask_flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
      wr_phase <= 1'b0;
      data_out <= '0;
      tc_pulse <= 1'b0;
      tc_ch    <= '0;
    end else begin
      addr_vld <= served;
      wr_phase <= served && m2m_en && (phase == PH_WRITE);
      tc_pulse <= served && step_tc;
      if (served) begin
        addr_out <= cur_addr[act_ch];
        tc_ch    <= act_ch;
        if (m2m_en && phase == PH_WRITE) data_out <= tmp;
      end
    end
  end
endmodule

// File: rtl/dma_addr_engine_chk.sv
module dma_addr_engine_chk #(
  parameter int CH_N = 4,
  localparam int CHW = $clog2(CH_N)
) (
  input logic            clk,
  input logic            rst,
  input logic            xfer_stb,
  input logic            m2m_en,
  input logic            addr_vld,
  input logic            wr_phase,
  input logic            tc_pulse,
  input logic [CHW-1:0]  tc_ch,
  input logic [CH_N-1:0] tc_flags,
  input logic [CH_N-1:0] mask_flags
);
  assert_vld_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    addr_vld |-> $past(xfer_stb));

  assert_tc_with_addr_R4: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> addr_vld);

  assert_tc_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> tc_flags[tc_ch]);

  assert_mask_only_at_tc_R5: assert property (@(posedge clk) disable iff (rst)
    (((mask_flags & ~$past(mask_flags)) != '0) && !$past(rst)) |-> tc_pulse);

  assert_wr_phase_in_m2m_R7: assert property (@(posedge clk) disable iff (rst)
    wr_phase |-> (addr_vld && $past(m2m_en)));

  assert_m2m_tc_on_dst_R8: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && $past(m2m_en)) |-> (tc_ch == CHW'(1)));
endmodule

bind dma_addr_engine dma_addr_engine_chk #(.CH_N(CH_N)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .xfer_stb   (xfer_stb),
  .m2m_en     (m2m_en),
  .addr_vld   (addr_vld),
  .wr_phase   (wr_phase),
  .tc_pulse   (tc_pulse),
  .tc_ch      (tc_ch),
  .tc_flags   (tc_flags),
  .mask_flags (mask_flags)
);

// File: tb/dma_addr_engine_tb_top.sv
module dma_addr_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0;
  logic [1:0]  load_ch = '0;
  logic [15:0] load_addr = '0;
  logic [15:0] load_cnt = '0;
  logic [3:0]  dir_down = '0;
  logic [3:0]  auto_init = '0;
  logic        m2m_en = 1'b0;
  logic        xfer_stb = 1'b0;
  logic [1:0]  xfer_ch = '0;
  logic [7:0]  data_in = '0;
  logic [15:0] addr_out;
  logic        addr_vld, wr_phase, tc_pulse;
  logic [7:0]  data_out;
  logic [1:0]  tc_ch;
  logic [3:0]  tc_flags, mask_flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_addr_engine dut_i (
    .clk(clk), .rst(rst), .load_we(load_we), .load_ch(load_ch),
    .load_addr(load_addr), .load_cnt(load_cnt), .dir_down(dir_down),
    .auto_init(auto_init), .m2m_en(m2m_en), .xfer_stb(xfer_stb),
    .xfer_ch(xfer_ch), .data_in(data_in), .addr_out(addr_out),
    .addr_vld(addr_vld), .wr_phase(wr_phase), .data_out(data_out),
    .tc_pulse(tc_pulse), .tc_ch(tc_ch), .tc_flags(tc_flags),
    .mask_flags(mask_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
    load_we = 1'b1; load_ch = ch; load_addr = a; load_cnt = c;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic strobe(input logic [1:0] ch);
    xfer_ch = ch; xfer_stb = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 masks after reset", 32'(mask_flags), 32'hF);
    check("R1 tc flags after reset", 32'(tc_flags), 32'h0);
    check("R1 no address after reset", 32'(addr_vld), 32'h0);
    strobe(2'd1);
    check("R1 masked strobe ignored", 32'(addr_vld), 32'h0);
  endtask

  task automatic t_up_count();
    load(2'd2, 16'h1000, 16'd2);
    check("R2 load unmasks", 32'(mask_flags[2]), 32'h0);
    for (int i = 0; i < 3; i++) begin
      strobe(2'd2);
      check("R3 vld up", 32'(addr_vld), 32'h1);
      check("R3 addr up", 32'(addr_out), 32'h1000 + i);
      check("R4 tc on third", 32'(tc_pulse), (i == 2) ? 32'h1 : 32'h0);
    end
    check("R4 tc channel", 32'(tc_ch), 32'h2);
    check("R5 tc flag", 32'(tc_flags[2]), 32'h1);
    check("R5 mask set", 32'(mask_flags[2]), 32'h1);
    strobe(2'd2);
    check("R5 masked ignores", 32'(addr_vld), 32'h0);
  endtask

  task automatic t_down_wrap();
    dir_down[3] = 1'b1;
    load(2'd3, 16'h0000, 16'd1);
    strobe(2'd3);
    check("R3 down first", 32'(addr_out), 32'h0000);
    check("R4 no early tc", 32'(tc_pulse), 32'h0);
    strobe(2'd3);
    check("R3 down wrap", 32'(addr_out), 32'hFFFF);
    check("R4 tc second", 32'(tc_pulse), 32'h1);
    dir_down[3] = 1'b0;
  endtask

  task automatic t_single();
    load(2'd0, 16'h0ABC, 16'd0);
    strobe(2'd0);
    check("R4 count zero one byte tc", 32'(tc_pulse), 32'h1);
    check("R4 count zero addr", 32'(addr_out), 32'h0ABC);
  endtask

  task automatic t_autoinit();
    auto_init[1] = 1'b1;
    load(2'd1, 16'h0200, 16'd1);
    strobe(2'd1);
    check("R6 first", 32'(addr_out), 32'h0200);
    strobe(2'd1);
    check("R6 tc", 32'(tc_pulse), 32'h1);
    check("R6 mask clear", 32'(mask_flags[1]), 32'h0);
    check("R6 flag set", 32'(tc_flags[1]), 32'h1);
    strobe(2'd1);
    check("R6 reload vld", 32'(addr_vld), 32'h1);
    check("R6 reload addr", 32'(addr_out), 32'h0200);
    strobe(2'd1);
    check("R6 reloaded count tc", 32'(tc_pulse), 32'h1);
    auto_init[1] = 1'b0;
  endtask

  task automatic t_conflict();
    xfer_stb = 1'b1; xfer_ch = 2'd2;
    load_we = 1'b1; load_ch = 2'd2; load_addr = 16'h7700; load_cnt = 16'd5;
    @(negedge clk);
    xfer_stb = 1'b0; load_we = 1'b0;
    check("R2 strobe dropped on load", 32'(addr_vld), 32'h0);
    check("R2 tc flag cleared", 32'(tc_flags[2]), 32'h0);
    strobe(2'd2);
    check("R2 new address", 32'(addr_out), 32'h7700);
  endtask

  task automatic t_m2m();
    load(2'd0, 16'h4000, 16'd0);
    load(2'd1, 16'h8000, 16'd1);
    m2m_en = 1'b1;
    for (int b = 0; b < 2; b++) begin
      data_in = (b == 0) ? 8'hAA : 8'h55;
      strobe(2'd3);
      check("R7 read vld", 32'(addr_vld), 32'h1);
      check("R7 read phase", 32'(wr_phase), 32'h0);
      check("R7 read addr", 32'(addr_out), 32'h4000 + b);
      check("R8 no tc on read", 32'(tc_pulse), 32'h0);
      data_in = 8'h00;
      strobe(2'd3);
      check("R7 write phase", 32'(wr_phase), 32'h1);
      check("R7 write addr", 32'(addr_out), 32'h8000 + b);
      check("R7 write data", 32'(data_out), (b == 0) ? 32'hAA : 32'h55);
      check("R8 tc on last write", 32'(tc_pulse), (b == 1) ? 32'h1 : 32'h0);
    end
    check("R8 tc channel", 32'(tc_ch), 32'h1);
    check("R8 dst masked", 32'(mask_flags[1]), 32'h1);
    check("R8 src unmasked", 32'(mask_flags[0]), 32'h0);
    strobe(2'd0);
    check("R8 pair masked ignores", 32'(addr_vld), 32'h0);
    m2m_en = 1'b0;
    @(negedge clk);
    strobe(2'd0);
    check("R8 src addr kept stepping", 32'(addr_out), 32'h4002);
    check("R8 src count untouched", 32'(tc_pulse), 32'h1);
    check("R8 src tc channel", 32'(tc_ch), 32'h0);
  endtask

  task automatic t_full_burst();
    int ntc = 0;
    int tc_at = -1;
    int nvld = 0;
    logic [15:0] last = '0;
    load(2'd3, 16'h0010, 16'hFFFF);
    xfer_ch = 2'd3; xfer_stb = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (addr_vld) nvld++;
      if (tc_pulse) begin ntc++; tc_at = i; end
      last = addr_out;
    end
    xfer_stb = 1'b0;
    check("R4 64K transfers", 32'(nvld), 32'd65536);
    check("R4 single tc", 32'(ntc), 32'd1);
    check("R4 tc on 65536th", 32'(tc_at), 32'd65535);
    check("R3 wrap over burst", 32'(last), 32'h000F);
    strobe(2'd3);
    check("R9 no vld after burst", 32'(addr_vld), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_up_count();
    t_down_wrap();
    t_single();
    t_autoinit();
    t_conflict();
    t_m2m();
    t_full_burst();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule